// File: doc/BRIEF.md
# Cascaded Low-Power Memory Array

This block is a deep single-port synchronous memory assembled from a parameterised number of identical RAM banks, all stacked in one chain. An address is split in two. The low bits pick a word inside a bank and reach every bank in parallel, together with the write data and the write enable. The high bits are decoded into a one-hot bank enable, so only the addressed bank is active in a given cycle. All other banks keep their storage and their read register unchanged, which keeps dynamic power low.

Read data does not go through one wide output multiplexer fed by every bank. Each bank owns a cascade stage. That stage chooses between the bank's own read word and the word arriving from the stage below it, then passes the result upward. Any stage can carry a pipeline register, chosen per stage by a bit mask. Each access travels up the chain as a hit flag paired with a data word. A stage delays its own bank's word by the number of pipeline registers below it, so all accesses see the same fixed latency and results come out in issue order.

Top module: `cascade_mem_top`

## Requirements
- R1: While `acc_en` is 1, `bank_en` has exactly one bit set, at index `acc_addr[AW-1:log2(BANK_DEPTH)]`. Bank 0 holds the lowest addresses. While `acc_en` is 0, `bank_en` is all zeros.
- R2: An access with `acc_we`=1 stores `acc_wdata` at `acc_addr`. No other location in any bank changes.
- R3: An access with `acc_we`=0 returns the word last written to `acc_addr`, for addresses in every bank.
- R4: Every access, write or read, returns on `rd_data` the content the location held before that access. A write therefore returns the old word (read-first).
- R5: `rd_valid` is 1 for exactly one cycle per access. That cycle comes 1 + (number of set bits in `PIPE_MASK[NUM_BANKS-1:0]`) clock edges after the edge that sampled the access. Accesses issued on consecutive cycles return on consecutive cycles, in issue order.
- R6: While `acc_en` is 0, no result is produced (`rd_valid` stays 0). A bank that is not enabled holds its read register unchanged.
- R7: During and right after a synchronous active-low reset, `rd_valid` is 0, `rd_data` is 0 and `bank_en` is 0 with `acc_en` low. Stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW = log2(NUM_BANKS*BANK_DEPTH) | Word address; the high bits select the bank |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data at the top of the cascade |
| rd_valid | output | 1 | `rd_data` holds the result of an access |
| bank_en | output | NUM_BANKS | One-hot bank enable decoded from the address |

## Verification
The bench builds four banks of sixteen 16-bit words with `PIPE_MASK` = 8'h05. That puts pipeline registers on stages 0 and 2 and leaves stages 1 and 3 combinational, for a latency of three cycles. With this mix, a bank above a pipelined stage must delay its own word by one or two cycles, while bank 0 needs no delay. Back-to-back reads that hop between banks then show at the ports whether tokens from different banks collide or get reordered. A sweep over all 64 addresses reaches both ends of every bank and every bank-select value.

// File: rtl/cmem_pkg.sv
// Package: shared helpers for the cascaded memory.
// Assumes the pipeline mask is at most 8 bits wide (up to 8 banks).
package cmem_pkg;

    // Counts the pipelined stages strictly below a given stage.
    function automatic int pipes_below(input logic [7:0] mask, input int stage);
        int n;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (i < stage && mask[i]) n++;
        end
        return n;
    endfunction

    // Counts the pipelined stages in a chain of the given length.
    function automatic int pipes_total(input logic [7:0] mask, input int banks);
        return pipes_below(mask, banks);
    endfunction

endpackage

// File: rtl/cmem_decode.sv
// Module: bank-select decoder.
// Turns the upper address bits into a one-hot enable and gates it with the
// access request. Assumes NUM_BANKS is a power of two, so every select
// value names a real bank.
module cmem_decode #(
    parameter int NUM_BANKS = 4,
    localparam int SW = $clog2(NUM_BANKS)
) (
    input  logic                 en_i,
    input  logic [SW-1:0]        sel_i,
    output logic [NUM_BANKS-1:0] bank_en_o
);

    // Purpose: set exactly one enable bit per access, none when idle.
    always_comb begin
        bank_en_o = '0;
        if (en_i) bank_en_o[sel_i] = 1'b1;
    end

endmodule

// File: rtl/cmem_bank.sv
// Module: one RAM bank with a registered, read-first port.
// Storage is not reset. The read register and hit flag are reset. When the
// bank is not enabled, its read register holds, so the bank does not toggle.
module cmem_bank #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    localparam int DAW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [DAW-1:0]    addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              hit_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: write the addressed word when this bank is enabled for a write.
    always_ff @(posedge clk) begin
        if (en_i && we_i) mem[addr_i] <= wdata_i;
    end

    // Purpose: read-first capture of the old word and the hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            hit_o   <= 1'b0;
        end else begin
            hit_o <= en_i;
            if (en_i) rdata_o <= mem[addr_i];
        end
    end

    // A bank left idle keeps its read register.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(rdata_o));

endmodule

// File: rtl/cmem_stage.sv
// Module: one cascade stage.
// It delays the bank's own word and hit by ALIGN cycles, the number of
// pipeline registers below this stage, so that the word lines up with the
// cascade input. It then picks own data over cascade data and, if PIPE is
// set, registers the result. It assumes at most one of the two inputs hits
// in any cycle.
module cmem_stage #(
    parameter int DATA_W = 16,
    parameter int ALIGN  = 0,
    parameter bit PIPE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_hit_i,
    input  logic [DATA_W-1:0] own_data_i,
    input  logic              casc_hit_i,
    input  logic [DATA_W-1:0] casc_data_i,
    output logic              out_hit_o,
    output logic [DATA_W-1:0] out_data_o
);

    logic [DATA_W-1:0] al_d [ALIGN+1];
    logic              al_h [ALIGN+1];
    logic [DATA_W-1:0] mux_d;
    logic              mux_h;

    assign al_d[0] = own_data_i;
    assign al_h[0] = own_hit_i;

    genvar j;
    generate
        for (j = 0; j < ALIGN; j++) begin : g_align
            // Purpose: one alignment register for the bank's own word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    al_d[j+1] <= '0;
                    al_h[j+1] <= 1'b0;
                end else begin
                    al_d[j+1] <= al_d[j];
                    al_h[j+1] <= al_h[j];
                end
            end
        end
    endgenerate

    // Purpose: the cascade multiplexer, own word first.
    always_comb begin
        mux_d = al_h[ALIGN] ? al_d[ALIGN] : casc_data_i;
        mux_h = al_h[ALIGN] | casc_hit_i;
    end

    generate
        if (PIPE) begin : g_pipe
            // Purpose: optional pipeline register on the cascade path.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_data_o <= '0;
                    out_hit_o  <= 1'b0;
                end else begin
                    out_data_o <= mux_d;
                    out_hit_o  <= mux_h;
                end
            end
        end else begin : g_comb
            assign out_data_o = mux_d;
            assign out_hit_o  = mux_h;
        end
    endgenerate

    // Tokens from two banks never meet at one stage (keeps order, R5).
    assert_no_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(al_h[ALIGN] && casc_hit_i));

endmodule

// File: rtl/cascade_mem_top.sv
// Module: cascaded low-power memory, top level.
// It splits the address, decodes one bank enable per access and sends the
// common inputs to every bank. Read data climbs the stage chain from bank 0
// to the top. A shift register of the fixed latency drives rd_valid.
// Assumes NUM_BANKS is a power of two from 2 to 8, BANK_DEPTH is a power of
// two of at least 2, and PIPE_MASK bits above NUM_BANKS-1 are ignored.
module cascade_mem_top #(
    parameter int         NUM_BANKS  = 4,
    parameter int         BANK_DEPTH = 16,
    parameter int         DATA_W     = 16,
    parameter logic [7:0] PIPE_MASK  = 8'h05,
    localparam int DAW = $clog2(BANK_DEPTH),
    localparam int SW  = $clog2(NUM_BANKS),
    localparam int AW  = DAW + SW,
    localparam int LAT = 1 + cmem_pkg::pipes_total(PIPE_MASK, NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic                 acc_we,
    input  logic [AW-1:0]        acc_addr,
    input  logic [DATA_W-1:0]    acc_wdata,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [NUM_BANKS-1:0] bank_en
);

    logic [DATA_W-1:0] bank_q   [NUM_BANKS];
    logic              bank_hit [NUM_BANKS];
    logic [DATA_W-1:0] ch_data  [NUM_BANKS+1];
    logic              ch_hit   [NUM_BANKS+1];
    logic [LAT-1:0]    vshift;

    cmem_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .en_i      (acc_en),
        .sel_i     (acc_addr[AW-1:DAW]),
        .bank_en_o (bank_en)
    );

    assign ch_data[0] = '0;
    assign ch_hit[0]  = 1'b0;

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int ALIGN_B = cmem_pkg::pipes_below(PIPE_MASK, b);

            cmem_bank #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_i    (bank_en[b]),
                .we_i    (acc_we),
                .addr_i  (acc_addr[DAW-1:0]),
                .wdata_i (acc_wdata),
                .rdata_o (bank_q[b]),
                .hit_o   (bank_hit[b])
            );

            cmem_stage #(.DATA_W(DATA_W), .ALIGN(ALIGN_B), .PIPE(PIPE_MASK[b])) u_stage (
                .clk         (clk),
                .rst_n       (rst_n),
                .own_hit_i   (bank_hit[b]),
                .own_data_i  (bank_q[b]),
                .casc_hit_i  (ch_hit[b]),
                .casc_data_i (ch_data[b]),
                .out_hit_o   (ch_hit[b+1]),
                .out_data_o  (ch_data[b+1])
            );
        end
    endgenerate

    // Purpose: latency bookkeeping; one bit per accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) vshift <= '0;
        else        vshift <= (vshift << 1) | LAT'(acc_en);
    end

    assign rd_valid = vshift[LAT-1];
    assign rd_data  = ch_data[NUM_BANKS];

    // One bank enabled per access.
    assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> ($countones(bank_en) == 1));
    // No bank enabled when idle.
    assert_idle_banks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (bank_en == '0));
    // Latency counter and cascade hit agree.
    assert_valid_matches_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == ch_hit[NUM_BANKS]);
    // Nothing valid in the cycle right after reset.
    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> !rd_valid);

endmodule

// File: tb/sim_cascade_mem_top.sv
`timescale 1ns/1ps
module sim_cascade_mem_top;

    localparam int         NB   = 4;
    localparam int         BD   = 16;
    localparam int         W    = 16;
    localparam logic [7:0] MASK = 8'h05;
    localparam int         AW   = 6;
    localparam int         TOT  = NB * BD;
    localparam int         LAT  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_en = 1'b0;
    logic          acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [W-1:0]  acc_wdata = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic [NB-1:0] bank_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [W-1:0] ref_mem [TOT];
    logic [W-1:0] exp_q [$];
    int           iss_q [$];
    bit           chk_q [$];
    string        req_q [$];

    always #2.5 clk = ~clk;

    cascade_mem_top #(.NUM_BANKS(NB), .BANK_DEPTH(BD), .DATA_W(W), .PIPE_MASK(MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .bank_en(bank_en)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Result monitor: ordering, latency and data (R3, R4, R5, R6).
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected rd_valid", 1, 0);
                end else begin
                    logic [W-1:0] e;
                    int t;
                    bit c;
                    string r;
                    e = exp_q.pop_front();
                    t = iss_q.pop_front();
                    c = chk_q.pop_front();
                    r = req_q.pop_front();
                    check((cyc - t) == LAT, "R5 latency", cyc - t, LAT);
                    if (c) check(rd_data == e, r, rd_data, e);
                end
            end else if (iss_q.size() != 0 && (cyc - iss_q[0]) >= LAT) begin
                check(1'b0, "R5 missing rd_valid", 0, 1);
                void'(exp_q.pop_front());
                void'(iss_q.pop_front());
                void'(chk_q.pop_front());
                void'(req_q.pop_front());
            end
        end
    end

    // One access in the next cycle; checks the bank decode (R1).
    task automatic access(input bit we, input int a, input logic [W-1:0] d,
                          input bit chk, input string req);
        @(negedge clk);
        #1;
        acc_en = 1'b1;
        acc_we = we;
        acc_addr = AW'(a);
        acc_wdata = d;
        exp_q.push_back(ref_mem[a]);
        iss_q.push_back(cyc);
        chk_q.push_back(chk);
        req_q.push_back(req);
        if (we) ref_mem[a] = d;
        #0.5;
        check(bank_en == NB'(1 << (a / BD)), "R1 bank_en one-hot", bank_en, 1 << (a / BD));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            acc_en = 1'b0;
            acc_we = 1'b0;
            #0.5;
            check(bank_en == '0, "R1 idle bank_en", bank_en, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(rd_valid == 1'b0, "R7 rd_valid in reset", rd_valid, 0);
        check(rd_data == '0, "R7 rd_data in reset", rd_data, 0);
        check(bank_en == '0, "R7 bank_en in reset", bank_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(rd_valid == 1'b0, "R7 rd_valid after reset", rd_valid, 0);
    endtask

    // Fill every location, old contents unknown.
    task automatic t_fill();
        for (int a = 0; a < TOT; a++) access(1'b1, a, W'(16'hA000 + a * 16'h0101), 1'b0, "R2");
        idle(LAT + 1);
    endtask

    // Sweep all banks, back to back.
    task automatic t_read_all();
        for (int a = 0; a < TOT; a++) access(1'b0, a, '0, 1'b1, "R3 read sweep");
        idle(LAT + 1);
    endtask

    // Random writes, then readback of everything (R2 only target changes).
    task automatic t_random_writes();
        for (int i = 0; i < 40; i++) access(1'b1, int'($urandom_range(TOT - 1)), W'($urandom), 1'b1, "R4 write old data");
        idle(2);
        for (int a = TOT - 1; a >= 0; a--) access(1'b0, a, '0, 1'b1, "R2 readback");
        idle(LAT + 1);
    endtask

    // Read-first on repeated writes to one address in each bank.
    task automatic t_read_first();
        for (int b = 0; b < NB; b++) begin
            access(1'b1, b * BD + 5, W'(16'h5500 + b), 1'b1, "R4 first write");
            access(1'b1, b * BD + 5, W'(16'h66F0 + b), 1'b1, "R4 second write returns prior");
            access(1'b0, b * BD + 5, '0, 1'b1, "R4 read after writes");
        end
        idle(LAT + 1);
    endtask

    // Hop between top and bottom banks every cycle, with gaps (R5, R6).
    task automatic t_hop();
        for (int i = 0; i < 24; i++) begin
            int a;
            a = (i % 2 == 0) ? (TOT - 1 - i) : i;
            access(1'b0, a, '0, 1'b1, "R5 bank hop order");
            if (i % 7 == 6) idle(1 + i % 3);
        end
        idle(LAT + 4);
        check(exp_q.size() == 0, "R6 no pending after idle", exp_q.size(), 0);
    endtask

    initial begin
        for (int a = 0; a < TOT; a++) ref_mem[a] = '0;
        t_reset();
        t_fill();
        t_read_all();
        t_random_writes();
        t_read_first();
        t_hop();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R5 watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule